// File: doc/BRIEF.md
# Serial Port Circular Autobuffer Controller

This block moves words between a serial port and data memory without the processor taking part. The transmit side asks for a word by pulsing `txReq`. The block reads it from memory and presents it on `txData`. The receive side pulses `rxReq` with a word on `rxData`, and the block writes that word to memory. Each direction takes its pointer from a shared bank of eight index registers. The same bank holds eight modify registers and eight length registers, so every pointer can walk a circular buffer.

A 16-bit control word selects the setup for each direction. For each direction it holds an enable bit, an index-register number, and a two-bit modify field. The upper bit of the modify-register number always comes from the chosen index register, so an index/modify pair stays inside one half of the bank. A direction's interrupt pulses only when its pointer wraps past the end of its buffer. Reset clears both enables, and so does a `reboot` pulse, after which software must turn autobuffering on again.

Both directions share one memory port. Pending requests are served one per cycle, with transmit ahead of receive.

Top module: `serial_autobuf`

## Requirements
- R1: The control word maps fields as follows: bit 0 is the receive enable, bits 3:1 the receive index number, bits 5:4 the receive modify field, bit 6 the transmit enable, bits 9:7 the transmit index number and bits 11:10 the transmit modify field. `ctrlRdData` returns this word, and bits 15:12 always read zero.
- R2: Each enable acts on its own direction only. A request that arrives while its direction is disabled is dropped: no memory access happens, neither then nor after a later re-enable, and no pointer changes.
- R3: The modify register used by a direction is number {index number bit 2, modify field}, so index register 6 with modify field 0 uses modify register 4.
- R4: An access goes to the current value of the selected index register. That register then becomes index plus modify, with modify read as two's complement. A receive access writes the word that was captured with its request.
- R5: For a nonzero length L, the buffer base is the index with its low bits cleared, over the smallest power of two that is at least L. A step reaching base+L or beyond wraps down by L, and a negative step going below the base wraps up by L.
- R6: A length of zero gives linear addressing, modulo the address width, with no wrap and no interrupt.
- R7: `txIrq` or `rxIrq` is high for exactly one cycle. That cycle follows the access of that direction whose step wrapped, and the interrupt never fires for a step without a wrap.
- R8: Reset clears the whole control word. A `reboot` pulse clears both enable bits and drops any pending request, including one that arrives in the same cycle.
- R9: At most one memory access happens per cycle. When both directions are pending, the transmit read goes first and the receive write follows in the next cycle.
- R10: A word read for transmit in cycle N appears on `txData` from cycle N+2 and holds until the next transmit read lands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reboot | input | 1 | One-cycle pulse that clears both enables and pending requests |
| ctrlWr | input | 1 | Write strobe for the control word |
| ctrlWrData | input | 16 | Control word to write |
| ctrlRdData | output | 16 | Current control word |
| bankWr | input | 1 | Write strobe for the register bank |
| bankSel | input | 2 | Bank file: 0 index, 1 modify, 2 length, 3 none |
| bankNum | input | 3 | Bank register number |
| bankWrData | input | ADDR_W | Value for the bank register |
| txReq | input | 1 | Transmit side wants a word |
| txData | output | DATA_W | Last word fetched for transmit |
| rxReq | input | 1 | Receive side has a word |
| rxData | input | DATA_W | Received word, taken with `rxReq` |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory address |
| memWrData | output | DATA_W | Memory write data |
| memRdData | input | DATA_W | Read data, valid the cycle after `memRd` |
| txIrq | output | 1 | Transmit end-of-buffer pulse |
| rxIrq | output | 1 | Receive end-of-buffer pulse |

## Verification
The bench builds the block with ADDR_W = 8 and DATA_W = 16. That keeps the whole 256-word memory inside the bench, and a modify value of 0xFF becomes a true negative step of one. With these widths, a five-word buffer aligned on eight, a four-word buffer walked backwards, and a linear pointer that runs off the top of the address space all fit inside a short run. The reference model compares with the design every cycle through directed and random request patterns.

// File: rtl/autobuf_pkg.sv
package autobuf_pkg;

  localparam int CTRL_W       = 16;
  localparam int REG_NUM_W    = 3;
  localparam int MOD_FIELD_W  = 2;
  localparam int NUM_BANK_REGS = 1 << REG_NUM_W;

  // control word bit positions (fixed layout, software decodes it)
  localparam int RX_EN_BIT   = 0;
  localparam int RX_IDX_LSB  = 1;
  localparam int RX_MOD_LSB  = RX_IDX_LSB + REG_NUM_W;
  localparam int TX_EN_BIT   = RX_MOD_LSB + MOD_FIELD_W;
  localparam int TX_IDX_LSB  = TX_EN_BIT + 1;
  localparam int TX_MOD_LSB  = TX_IDX_LSB + REG_NUM_W;
  localparam int CTRL_USED   = TX_MOD_LSB + MOD_FIELD_W;
  localparam logic [CTRL_W-1:0] CTRL_MASK = CTRL_W'((1 << CTRL_USED) - 1);

  typedef enum logic [1:0] {
    BANK_INDEX  = 2'd0,
    BANK_MODIFY = 2'd1,
    BANK_LENGTH = 2'd2,
    BANK_NONE   = 2'd3
  } bankFile_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 grantTx;
    logic                 grantRx;
    logic                 loadTx;
    logic [REG_NUM_W-1:0] txIdx;
    logic [REG_NUM_W-1:0] txMod;
    logic [REG_NUM_W-1:0] rxIdx;
    logic [REG_NUM_W-1:0] rxMod;
  } abStrobe_t;

endpackage

// File: rtl/autobuf_modstep.sv
module autobuf_modstep #(
  parameter int ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] modVal,
  input  logic [ADDR_W-1:0] lenVal,
  output logic [ADDR_W-1:0] nextPtr,
  output logic              wrap
);
  localparam int SUM_W = ADDR_W + 2;

  logic [ADDR_W-1:0] lenM1;
  logic [ADDR_W-1:0] alignMask;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] linear;
  logic [SUM_W-1:0]  wideSum;
  logic [SUM_W-1:0]  limit;
  logic              negStep;

  assign lenM1 = lenVal - ADDR_W'(1);

  // all bits at or below the highest set bit of (L-1)
  always_comb begin
    for (int i = 0; i < ADDR_W; i++) begin
      alignMask[i] = |(lenM1 >> i);
    end
  end

  assign base    = ptr & ~alignMask;
  assign negStep = modVal[ADDR_W-1];
  assign linear  = ptr + modVal;
  assign wideSum = {2'b00, ptr} + {{2{negStep}}, modVal};
  assign limit   = {2'b00, base} + {2'b00, lenVal};

  always_comb begin
    nextPtr = linear;
    wrap    = 1'b0;
    if (lenVal != '0) begin
      if (!negStep && (wideSum >= limit)) begin
        nextPtr = linear - lenVal;
        wrap    = 1'b1;
      end else if (negStep && ($signed(wideSum) < $signed({2'b00, base}))) begin
        nextPtr = linear + lenVal;
        wrap    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/autobuf_ctrl.sv
module autobuf_ctrl import autobuf_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reboot,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] ctrlWrData,
  output logic [CTRL_W-1:0] ctrlRdData,
  input  logic              txReq,
  input  logic              rxReq,
  input  logic              wrapHit,
  output abStrobe_t         strobe,
  output logic              rxCapture,
  output logic              txIrq,
  output logic              rxIrq
);
  logic [CTRL_W-1:0] ctrlQ, ctrlNext;
  logic txPend, rxPend, txPendNext, rxPendNext;
  logic txEn, rxEn, grantTx, grantRx, loadTxQ;

  assign txEn = ctrlQ[TX_EN_BIT];
  assign rxEn = ctrlQ[RX_EN_BIT];

  always_comb begin
    ctrlNext = ctrlQ;
    if (ctrlWr) ctrlNext = ctrlWrData & CTRL_MASK;
    if (reboot) begin
      ctrlNext[TX_EN_BIT] = 1'b0;
      ctrlNext[RX_EN_BIT] = 1'b0;
    end
  end

  // fixed priority: transmit first
  assign grantTx = txPend & txEn;
  assign grantRx = rxPend & rxEn & ~grantTx;

  assign txPendNext = ~reboot & txEn & ((txPend & ~grantTx) | txReq);
  assign rxPendNext = ~reboot & rxEn & ((rxPend & ~grantRx) | rxReq);
  assign rxCapture  = rxReq & rxEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      txPend  <= 1'b0;
      rxPend  <= 1'b0;
      txIrq   <= 1'b0;
      rxIrq   <= 1'b0;
      loadTxQ <= 1'b0;
    end else begin
      ctrlQ   <= ctrlNext;
      txPend  <= txPendNext;
      rxPend  <= rxPendNext;
      txIrq   <= grantTx & wrapHit;
      rxIrq   <= grantRx & wrapHit;
      loadTxQ <= grantTx;
    end
  end

  always_comb begin
    strobe.grantTx = grantTx;
    strobe.grantRx = grantRx;
    strobe.loadTx  = loadTxQ;
    strobe.txIdx   = ctrlQ[TX_IDX_LSB +: REG_NUM_W];
    strobe.txMod   = {ctrlQ[TX_IDX_LSB + REG_NUM_W - 1], ctrlQ[TX_MOD_LSB +: MOD_FIELD_W]};
    strobe.rxIdx   = ctrlQ[RX_IDX_LSB +: REG_NUM_W];
    strobe.rxMod   = {ctrlQ[RX_IDX_LSB + REG_NUM_W - 1], ctrlQ[RX_MOD_LSB +: MOD_FIELD_W]};
  end

  assign ctrlRdData = ctrlQ;

  assert_reboot_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    reboot |=> (ctrlRdData[TX_EN_BIT] == 1'b0 && ctrlRdData[RX_EN_BIT] == 1'b0));

  assert_disabled_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && !txEn && !txPend) |=> !strobe.grantTx);

  assert_tx_irq_after_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> $past(strobe.grantTx));

  assert_rx_irq_after_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> $past(strobe.grantRx));

  assert_single_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(txIrq && rxIrq));

endmodule

// File: rtl/autobuf_dpath.sv
module autobuf_dpath import autobuf_pkg::*; #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  abStrobe_t            strobe,
  input  logic                 rxCapture,
  input  logic [DATA_W-1:0]    rxData,
  input  logic                 bankWr,
  input  logic [1:0]           bankSel,
  input  logic [REG_NUM_W-1:0] bankNum,
  input  logic [ADDR_W-1:0]    bankWrData,
  input  logic [DATA_W-1:0]    memRdData,
  output logic                 memRd,
  output logic                 memWr,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWrData,
  output logic [DATA_W-1:0]    txData,
  output logic                 wrapHit
);
  logic [ADDR_W-1:0] idxReg [NUM_BANK_REGS];
  logic [ADDR_W-1:0] modReg [NUM_BANK_REGS];
  logic [ADDR_W-1:0] lenReg [NUM_BANK_REGS];
  logic [REG_NUM_W-1:0] actIdx, actMod;
  logic [ADDR_W-1:0] actPtr, actStep, actLen, nextPtr;
  logic [DATA_W-1:0] rxHold;
  logic grantAny;

  assign grantAny = strobe.grantTx | strobe.grantRx;
  assign actIdx   = strobe.grantTx ? strobe.txIdx : strobe.rxIdx;
  assign actMod   = strobe.grantTx ? strobe.txMod : strobe.rxMod;
  assign actPtr   = idxReg[actIdx];
  assign actStep  = modReg[actMod];
  assign actLen   = lenReg[actIdx];

  autobuf_modstep #(.ADDR_W(ADDR_W)) u_step (
    .ptr     (actPtr),
    .modVal  (actStep),
    .lenVal  (actLen),
    .nextPtr (nextPtr),
    .wrap    (wrapHit)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_BANK_REGS; k++) begin
        idxReg[k] <= '0;
        modReg[k] <= '0;
        lenReg[k] <= '0;
      end
    end else begin
      for (int k = 0; k < NUM_BANK_REGS; k++) begin
        if (bankWr && bankNum == REG_NUM_W'(k) && bankSel == BANK_INDEX)
          idxReg[k] <= bankWrData;
        else if (grantAny && actIdx == REG_NUM_W'(k))
          idxReg[k] <= nextPtr;
        if (bankWr && bankNum == REG_NUM_W'(k) && bankSel == BANK_MODIFY)
          modReg[k] <= bankWrData;
        if (bankWr && bankNum == REG_NUM_W'(k) && bankSel == BANK_LENGTH)
          lenReg[k] <= bankWrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxHold <= '0;
      txData <= '0;
    end else begin
      if (rxCapture)     rxHold <= rxData;
      if (strobe.loadTx) txData <= memRdData;
    end
  end

  assign memRd     = strobe.grantTx;
  assign memWr     = strobe.grantRx;
  assign memAddr   = actPtr;
  assign memWrData = rxHold;

  assert_one_access_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  assert_linear_no_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (grantAny && actLen == '0) |-> !wrapHit);

endmodule

// File: rtl/serial_autobuf.sv
module serial_autobuf import autobuf_pkg::*; #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reboot,
  input  logic                 ctrlWr,
  input  logic [CTRL_W-1:0]    ctrlWrData,
  output logic [CTRL_W-1:0]    ctrlRdData,
  input  logic                 bankWr,
  input  logic [1:0]           bankSel,
  input  logic [REG_NUM_W-1:0] bankNum,
  input  logic [ADDR_W-1:0]    bankWrData,
  input  logic                 txReq,
  output logic [DATA_W-1:0]    txData,
  input  logic                 rxReq,
  input  logic [DATA_W-1:0]    rxData,
  output logic                 memRd,
  output logic                 memWr,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWrData,
  input  logic [DATA_W-1:0]    memRdData,
  output logic                 txIrq,
  output logic                 rxIrq
);
  abStrobe_t strobe;
  logic rxCapture, wrapHit;

  autobuf_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reboot     (reboot),
    .ctrlWr     (ctrlWr),
    .ctrlWrData (ctrlWrData),
    .ctrlRdData (ctrlRdData),
    .txReq      (txReq),
    .rxReq      (rxReq),
    .wrapHit    (wrapHit),
    .strobe     (strobe),
    .rxCapture  (rxCapture),
    .txIrq      (txIrq),
    .rxIrq      (rxIrq)
  );

  autobuf_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rxCapture  (rxCapture),
    .rxData     (rxData),
    .bankWr     (bankWr),
    .bankSel    (bankSel),
    .bankNum    (bankNum),
    .bankWrData (bankWrData),
    .memRdData  (memRdData),
    .memRd      (memRd),
    .memWr      (memWr),
    .memAddr    (memAddr),
    .memWrData  (memWrData),
    .txData     (txData),
    .wrapHit    (wrapHit)
  );

endmodule

// File: tb/sim_serial_autobuf.sv
module sim_serial_autobuf;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int FULL = 1 << AW;
  localparam int HALF = 1 << (AW - 1);
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0, reboot = 1'b0, ctrlWr = 1'b0, bankWr = 1'b0;
  logic [15:0] ctrlWrData = '0, ctrlRdData;
  logic [1:0] bankSel = '0;
  logic [2:0] bankNum = '0;
  logic [AW-1:0] bankWrData = '0, memAddr;
  logic txReq = 1'b0, rxReq = 1'b0;
  logic [DW-1:0] txData, rxData = '0, memWrData, memRdData = '0;
  logic memRd, memWr, txIrq, rxIrq;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_autobuf #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .reboot(reboot),
    .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData), .ctrlRdData(ctrlRdData),
    .bankWr(bankWr), .bankSel(bankSel), .bankNum(bankNum), .bankWrData(bankWrData),
    .txReq(txReq), .txData(txData), .rxReq(rxReq), .rxData(rxData),
    .memRd(memRd), .memWr(memWr), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData), .txIrq(txIrq), .rxIrq(rxIrq));

  int checks = 0, errors = 0, cyc = 0;
  bit started = 0;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory seen by the design
  logic [DW-1:0] tbMem [FULL];
  always @(posedge clk) begin
    if (memWr) tbMem[memAddr] <= memWrData;
    if (memRd) memRdData <= tbMem[memAddr];
  end

  // reference model
  int mI[8], mM[8], mL[8], mmem[FULL];
  int fTi, fTm, fRi, fRm, hold, rdVal, xTxData;
  bit eTx, eRx, pTx, pRx, rdQ, xTxIrq, xRxIrq, doRd, doWr, w;

  function automatic bit stepPtr(int r, int m);
    int p, base, n, ms;
    bit wr;
    ms = mM[m];
    if (ms >= HALF) ms -= FULL;
    n = mI[r] + ms;
    wr = 0;
    if (mL[r] != 0) begin
      p = 1;
      while (p < mL[r]) p *= 2;
      base = mI[r] - (mI[r] % p);
      if (ms >= 0 && n >= base + mL[r]) begin n -= mL[r]; wr = 1; end
      else if (ms < 0 && n < base) begin n += mL[r]; wr = 1; end
    end
    mI[r] = ((n % FULL) + FULL) % FULL;
    return wr;
  endfunction

  function automatic int expCtrl();
    return eRx | (fRi << 1) | (fRm << 4) | (eTx << 6) | (fTi << 7) | (fTm << 10);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < 8; k++) begin mI[k] = 0; mM[k] = 0; mL[k] = 0; end
      fTi = 0; fTm = 0; fRi = 0; fRm = 0; hold = 0; xTxData = 0; rdVal = 0;
      eTx = 0; eRx = 0; pTx = 0; pRx = 0; rdQ = 0; xTxIrq = 0; xRxIrq = 0;
    end else begin
      doRd = pTx && eTx;
      doWr = pRx && eRx && !doRd;
      if (rdQ) xTxData = rdVal;
      rdQ = doRd; xTxIrq = 0; xRxIrq = 0;
      if (doRd) begin
        rdVal = mmem[mI[fTi]];
        w = stepPtr(fTi, (fTi & 4) | fTm);
        xTxIrq = w; pTx = 0;
      end
      if (doWr) begin
        mmem[mI[fRi]] = hold;
        w = stepPtr(fRi, (fRi & 4) | fRm);
        xRxIrq = w; pRx = 0;
      end
      if (bankWr) begin
        if (bankSel == 0) mI[bankNum] = int'(bankWrData);
        if (bankSel == 1) mM[bankNum] = int'(bankWrData);
        if (bankSel == 2) mL[bankNum] = int'(bankWrData);
      end
      if (txReq && eTx) pTx = 1;
      if (rxReq && eRx) begin pRx = 1; hold = int'(rxData); end
      if (ctrlWr) begin
        eRx = ctrlWrData[0]; fRi = int'(ctrlWrData[3:1]); fRm = int'(ctrlWrData[5:4]);
        eTx = ctrlWrData[6]; fTi = int'(ctrlWrData[9:7]); fTm = int'(ctrlWrData[11:10]);
      end
      if (reboot) begin eTx = 0; eRx = 0; pTx = 0; pRx = 0; end
    end
  end

  // per-cycle comparison and monitors
  int rdCnt = 0, wrCnt = 0, txIrqCnt = 0, rxIrqCnt = 0, lastRdAddr = 0, lastWrAddr = 0, rdCyc = 0, wrCyc = 0;
  always @(negedge clk) begin
    if (started) begin
      bit eRd, eWr;
      eRd = pTx && eTx;
      eWr = pRx && eRx && !eRd;
      check("R9", "memRd", int'(memRd), int'(eRd));
      check("R9", "memWr", int'(memWr), int'(eWr));
      if (eRd) check("R4", "tx read address", int'(memAddr), mI[fTi]);
      if (eWr) begin
        check("R4", "rx write address", int'(memAddr), mI[fRi]);
        check("R4", "rx write data", int'(memWrData), hold);
      end
      check("R7", "txIrq", int'(txIrq), int'(xTxIrq));
      check("R7", "rxIrq", int'(rxIrq), int'(xRxIrq));
      check("R10", "txData", int'(txData), xTxData);
      check("R1", "ctrlRdData", int'(ctrlRdData), expCtrl());
      if (memRd) begin rdCnt++; lastRdAddr = int'(memAddr); rdCyc = cyc; end
      if (memWr) begin wrCnt++; lastWrAddr = int'(memAddr); wrCyc = cyc; end
      if (txIrq) txIrqCnt++;
      if (rxIrq) rxIrqCnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG) begin
      errors++;
      $display("FAIL R9 watchdog actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bankW(int sel, int num, int val);
    @(negedge clk);
    bankWr = 1'b1; bankSel = 2'(sel); bankNum = 3'(num); bankWrData = AW'(val);
    @(negedge clk);
    bankWr = 1'b0;
  endtask

  task automatic ctrlW(int val);
    @(negedge clk);
    ctrlWr = 1'b1; ctrlWrData = 16'(val);
    @(negedge clk);
    ctrlWr = 1'b0;
  endtask

  task automatic pulse(bit t, bit r, int d);
    @(negedge clk);
    txReq = t; rxReq = r; rxData = DW'(d);
    @(negedge clk);
    txReq = 1'b0; rxReq = 1'b0;
  endtask

  int s0, s1, s2;

  initial begin
    for (int i = 0; i < FULL; i++) begin
      tbMem[i] = DW'(i * 3 + 7);
      mmem[i] = (i * 3 + 7) % (1 << DW);
    end
    idle(3);
    rstN = 1'b1;
    idle(1);
    started = 1;
    #1;
    check("R8", "control after reset", int'(ctrlRdData), 0);
    check("R8", "memRd after reset", int'(memRd), 0);
    check("R8", "txIrq after reset", int'(txIrq), 0);

    bankW(0, 0, 16); bankW(2, 0, 5); bankW(1, 1, 1);
    bankW(0, 5, 100); bankW(2, 5, 0); bankW(1, 6, 3);
    bankW(0, 2, 40); bankW(2, 2, 4); bankW(1, 3, 255);
    bankW(0, 6, 200); bankW(2, 6, 0); bankW(1, 4, 2); bankW(1, 0, 7);
    bankW(3, 1, 99);

    // rx en, rx idx 5, rx mod 2, tx en, tx idx 0, tx mod 1, junk high bits
    ctrlW('hF46B);
    idle(1); #1;
    check("R1", "readback with high bits cleared", int'(ctrlRdData), 'h046B);

    // R5 R7: buffer of 5 at 16, step 1: five reads then wrap to 16
    s0 = txIrqCnt; s1 = rdCnt;
    for (int i = 0; i < 6; i++) begin pulse(1, 0, 0); idle(3); end
    #1;
    check("R7", "tx wrap pulses over six reads", txIrqCnt - s0, 1);
    check("R4", "tx read count", rdCnt - s1, 6);
    check("R5", "sixth read back at base", lastRdAddr, 16);
    check("R10", "txData holds word from address 16", int'(txData), 16 * 3 + 7);

    // R6: linear rx pointer at 100 stepping by 3
    s0 = rxIrqCnt;
    pulse(0, 1, 'hA001); idle(3);
    pulse(0, 1, 'hA002); idle(3);
    pulse(0, 1, 'hA003); idle(3);
    #1;
    check("R4", "rx word stored at 103", int'(tbMem[103]), 'hA002);
    check("R6", "no rx interrupt on linear buffer", rxIrqCnt - s0, 0);
    check("R6", "last linear write address", lastWrAddr, 106);

    // R9: both at once, tx first then rx
    pulse(1, 1, 'hB00B); idle(4); #1;
    check("R9", "rx write one cycle after tx read", wrCyc - rdCyc, 1);

    // R3: rx idx 6 mod field 0 -> modify reg 4; tx idx 2 mod field 3 -> modify reg 3
    ctrlW(1 | (6 << 1) | (1 << 6) | (2 << 7) | (3 << 10));
    pulse(0, 1, 'hC001); idle(3);
    pulse(0, 1, 'hC002); idle(3); #1;
    check("R3", "second rx word at 202", int'(tbMem[202]), 'hC002);
    check("R3", "rx step from modify reg 4", lastWrAddr, 202);

    // R5: negative step in buffer of 4 at 40
    s0 = txIrqCnt;
    pulse(1, 0, 0); idle(3); #1;
    check("R5", "tx read at 40", lastRdAddr, 40);
    check("R7", "negative wrap interrupt", txIrqCnt - s0, 1);
    pulse(1, 0, 0); idle(3); #1;
    check("R5", "read after backward wrap", lastRdAddr, 43);

    // R2: tx disabled request dropped for good
    s0 = rdCnt; s1 = wrCnt;
    ctrlW(1 | (6 << 1) | (2 << 7) | (3 << 10));
    pulse(1, 0, 0); idle(4);
    ctrlW(1 | (6 << 1) | (1 << 6) | (2 << 7) | (3 << 10));
    idle(4); #1;
    check("R2", "no read for disabled request", rdCnt - s0, 0);
    check("R2", "rx side untouched", wrCnt - s1, 0);

    // R8: reboot with rx request in same cycle
    s0 = wrCnt; s1 = rdCnt;
    @(negedge clk);
    reboot = 1'b1; rxReq = 1'b1; rxData = 16'hDEAD;
    @(negedge clk);
    reboot = 1'b0; rxReq = 1'b0;
    #1;
    check("R8", "enables cleared by reboot", int'(ctrlRdData) & 'h41, 0);
    pulse(1, 1, 'h1234); idle(4); #1;
    check("R8", "no write after reboot", wrCnt - s0, 0);
    check("R8", "no read after reboot", rdCnt - s1, 0);

    // random traffic
    ctrlW(1 | (6 << 1) | (1 << 6) | (2 << 7) | (3 << 10));
    s2 = rdCnt;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      txReq = ($urandom % 3) == 0;
      rxReq = ($urandom % 2) == 0;
      rxData = DW'($urandom);
    end
    @(negedge clk);
    txReq = 1'b0; rxReq = 1'b0;
    idle(5); #1;
    if (rdCnt == s2) check("R9", "random phase produced reads", 0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule